// File: doc/BRIEF.md
# Iterative Integer Divider with Overflow and Condition Flags

This block divides one 32-bit integer by another over several clock cycles, in either signed or unsigned mode. A caller presents the dividend, the divisor and the mode bits together with a one-cycle `start` pulse. A normal division runs a radix-2 restoring loop on the operand magnitudes and fixes the quotient sign at the end. The two cases with no representable quotient are caught when `start` is accepted and finish at once with a fixed result: a zero divisor, and a signed division of the most negative value by minus one.

Each completed operation can also update status. With overflow recording enabled, an overflow flag takes the overflow outcome of the operation, and a sticky summary flag collects every overflow until software clears it. With condition recording enabled, a 4-bit condition field is written from the signed quotient. The remainder is not produced.

Top module: `int_divider`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) both operands are unsigned and `quotient` is floor(dividend / divisor) for any non-zero divisor.
- R2: In signed mode both operands are two's complement and `quotient` is their quotient truncated toward zero, for any non-zero divisor except the pair 0x80000000 / 0xFFFFFFFF.
- R3: An overflow case is a zero divisor in either mode, or the signed pair 0x80000000 / 0xFFFFFFFF. Its quotient is 0, except a signed division by zero, which gives 0xFFFFFFFF when the dividend is negative and 0 otherwise. The same operand pair in unsigned mode is an ordinary division.
- R4: When `ovf_en` was high with the accepted `start`, `ovf` becomes 1 after an overflow case and 0 after a normal division; when it was low, `ovf` keeps its value.
- R5: `sov` becomes 1 whenever an operation sets `ovf` to 1, holds that value across later operations, and returns to 0 only on a clock edge where `sov_clr` is high and no overflow is being recorded.
- R6: When `rec_en` was high with the accepted `start`, `cond` is written at completion as bit 3 = quotient negative, bit 2 = quotient positive, bit 1 = quotient zero, bit 0 = the value of `sov` after that operation; when it was low, `cond` keeps its value.
- R7: A normal division raises `busy` after the edge that accepts `start`, keeps it high for 32 cycles and drops it in the cycle `done` rises, 32 cycles after the first `busy` cycle... precisely: `done` is high in the 33rd cycle after the accepting edge.
- R8: An overflow case never raises `busy`; `done` is high in the cycle right after the accepting edge.
- R9: A `start` pulse while `busy` is high is ignored: the running operation finishes with its own result and timing, and no extra completion follows.
- R10: `done` is high for one cycle per accepted operation; `quotient`, `ovf` and `cond` change only in a cycle where `done` is high.
- R11: While `rst_n` is low at a clock edge, `busy`, `done`, `quotient`, `ovf`, `sov` and `cond` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; accepted when `busy` is low |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| ovf_en | input | 1 | Record overflow for this operation |
| rec_en | input | 1 | Write the condition field for this operation |
| sov_clr | input | 1 | Clear the sticky summary overflow |
| dividend | input | 32 | Dividend |
| divisor | input | 32 | Divisor |
| busy | output | 1 | Iterative division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Result of the last completed operation |
| ovf | output | 1 | Overflow flag |
| sov | output | 1 | Sticky summary overflow |
| cond | output | 4 | Condition field {negative, positive, zero, summary} |

## Verification
The hardest situation to reach from the ports is a `start` arriving in the middle of a running division, together with the interplay of the sticky summary flag and its clear. The stimulus launches a long division, pulses `start` with different operands partway through, and checks both the first result and that no second completion appears. It then sequences an overflow, a normal division with overflow recording, and a clear pulse, so that `ovf` falls while `sov` stays up until the clear, with the condition field's low bit followed at each step.

// File: rtl/div_pkg.sv
// Package: shared types for the iterative divider.
// Assumes: operand width is fixed per instance by the WIDTH parameter.
package div_pkg;
    // Condition field layout, most significant bit first.
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic summ;
    } cond_t;
endpackage

// File: rtl/div_corner.sv
// Module: div_corner
// Detects the operand pairs that have no representable quotient and
// supplies their fixed result. Purely combinational.
// Assumes: operands are sampled with the start pulse by the caller.
module div_corner #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    input  logic             sgn_i,
    output logic             ovf_case_o,
    output logic [WIDTH-1:0] fixed_q_o
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic den_zero;
    logic neg_by_m1;

    // Classify the operand pair.
    always_comb begin
        den_zero   = (den_i == '0);
        neg_by_m1  = sgn_i && (num_i == MOST_NEG) && (den_i == ALL_ONES);
        ovf_case_o = den_zero || neg_by_m1;
    end

    // Fixed result: sign of the dividend spread on signed divide by zero.
    always_comb begin
        if (den_zero && sgn_i)
            fixed_q_o = {WIDTH{num_i[WIDTH-1]}};
        else
            fixed_q_o = '0;
    end
endmodule

// File: rtl/div_iter.sv
// Module: div_iter
// Radix-2 restoring divider on operand magnitudes; one quotient bit per
// cycle for WIDTH cycles. Exposes the final magnitude in its last cycle.
// Assumes: load is only raised while busy_o is low and the divisor is
// non-zero.
module div_iter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             sgn_i,
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    output logic             busy_o,
    output logic             last_o,
    output logic             neg_o,
    output logic [WIDTH-1:0] mag_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] STEPS = CW'(WIDTH);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [WIDTH-1:0] rem_q, dq_q, dvs_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH:0]   shifted, diff;
    logic             qbit;
    logic [WIDTH-1:0] rem_n, dq_n;
    logic [WIDTH-1:0] num_abs, den_abs;

    // Magnitudes of the incoming operands.
    always_comb begin
        num_abs = (sgn_i && num_i[WIDTH-1]) ? (~num_i + 1'b1) : num_i;
        den_abs = (sgn_i && den_i[WIDTH-1]) ? (~den_i + 1'b1) : den_i;
    end

    // One restoring step: shift in a dividend bit, trial subtract.
    always_comb begin
        shifted = {rem_q, dq_q[WIDTH-1]};
        diff    = shifted - {1'b0, dvs_q};
        qbit    = ~diff[WIDTH];
        rem_n   = qbit ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
        dq_n    = {dq_q[WIDTH-2:0], qbit};
    end

    // Iteration state: load on start, step while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dq_q   <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            neg_o  <= 1'b0;
            busy_o <= 1'b0;
        end else if (load_i) begin
            rem_q  <= '0;
            dq_q   <= num_abs;
            dvs_q  <= den_abs;
            cnt_q  <= STEPS;
            neg_o  <= sgn_i && (num_i[WIDTH-1] ^ den_i[WIDTH-1]);
            busy_o <= 1'b1;
        end else if (busy_o) begin
            rem_q <= rem_n;
            dq_q  <= dq_n;
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE)
                busy_o <= 1'b0;
        end
    end

    // Final step marker and magnitude.
    always_comb begin
        last_o = busy_o && (cnt_q == ONE);
        mag_o  = dq_n;
    end
endmodule

// File: rtl/div_flags.sv
// Module: div_flags
// Holds the overflow flag, the sticky summary flag and the condition
// field, updated on each completion according to the recording enables.
// Assumes: fin_i is high for exactly the cycle a result is committed.
module div_flags #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin_i,
    input  logic             oe_i,
    input  logic             rc_i,
    input  logic             ovf_case_i,
    input  logic             sov_clr_i,
    input  logic [WIDTH-1:0] res_i,
    output logic             ovf_o,
    output logic             sov_o,
    output div_pkg::cond_t   cond_o
);
    logic set_sov;
    logic sov_n;

    // Next summary value: a recorded overflow wins over a clear.
    always_comb begin
        set_sov = fin_i && oe_i && ovf_case_i;
        if (set_sov)
            sov_n = 1'b1;
        else if (sov_clr_i)
            sov_n = 1'b0;
        else
            sov_n = sov_o;
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o  <= 1'b0;
            sov_o  <= 1'b0;
            cond_o <= '0;
        end else begin
            sov_o <= sov_n;
            if (fin_i && oe_i)
                ovf_o <= ovf_case_i;
            if (fin_i && rc_i) begin
                cond_o.neg  <= res_i[WIDTH-1];
                cond_o.pos  <= !res_i[WIDTH-1] && (res_i != '0);
                cond_o.zero <= (res_i == '0);
                cond_o.summ <= sov_n;
            end
        end
    end
endmodule

// File: rtl/int_divider.sv
// Module: int_divider (top)
// Accepts a division on start, routes overflow cases to a one-cycle
// fixed-result path and others to the iterative core, applies the sign,
// registers the quotient and drives the completion pulse and flags.
// Assumes: operands and mode bits are valid in the cycle start is high.
module int_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             signed_mode,
    input  logic             ovf_en,
    input  logic             rec_en,
    input  logic             sov_clr,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic             ovf,
    output logic             sov,
    output logic [3:0]       cond
);
    logic             accept, is_ovf, corner_fin, load, fin;
    logic             it_last, it_neg;
    logic [WIDTH-1:0] fixed_q, it_mag, res;
    logic             lat_oe, lat_rc, use_oe, use_rc;
    div_pkg::cond_t   cond_s;

    div_corner #(.WIDTH(WIDTH)) u_corner (
        .num_i      (dividend),
        .den_i      (divisor),
        .sgn_i      (signed_mode),
        .ovf_case_o (is_ovf),
        .fixed_q_o  (fixed_q)
    );

    // Acceptance and routing of a new operation.
    always_comb begin
        accept     = start && !busy;
        corner_fin = accept && is_ovf;
        load       = accept && !is_ovf;
    end

    div_iter #(.WIDTH(WIDTH)) u_iter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .sgn_i  (signed_mode),
        .num_i  (dividend),
        .den_i  (divisor),
        .busy_o (busy),
        .last_o (it_last),
        .neg_o  (it_neg),
        .mag_o  (it_mag)
    );

    // Recording enables captured with an iterative operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_oe <= 1'b0;
            lat_rc <= 1'b0;
        end else if (load) begin
            lat_oe <= ovf_en;
            lat_rc <= rec_en;
        end
    end

    // Completion select, result sign fix-up and enable choice.
    always_comb begin
        fin    = corner_fin || it_last;
        res    = corner_fin ? fixed_q : (it_neg ? (~it_mag + 1'b1) : it_mag);
        use_oe = corner_fin ? ovf_en : lat_oe;
        use_rc = corner_fin ? rec_en : lat_rc;
    end

    // Result register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            quotient <= '0;
        end else begin
            done <= fin;
            if (fin)
                quotient <= res;
        end
    end

    div_flags #(.WIDTH(WIDTH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_i      (fin),
        .oe_i       (use_oe),
        .rc_i       (use_rc),
        .ovf_case_i (corner_fin),
        .sov_clr_i  (sov_clr),
        .res_i      (res),
        .ovf_o      (ovf),
        .sov_o      (sov),
        .cond_o     (cond_s)
    );

    // Flatten the condition field onto the port.
    assign cond = cond_s;
endmodule

// File: rtl/int_divider_chk.sv
// Module: int_divider_chk
// Protocol and flag checks for int_divider, attached by bind.
// Assumes: reset is asserted from time zero.
module int_divider_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sov_clr,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic             ovf,
    input logic             sov,
    input logic [3:0]       cond
);
    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7
    busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R9
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R5
    sov_follows_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> sov);

    // R5
    sov_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sov) |-> $past(sov_clr));

    // R10
    quot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient));

    // R4
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ovf));

    // R6
    cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cond));
endmodule

bind int_divider int_divider_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sov_clr  (sov_clr),
    .busy     (busy),
    .done     (done),
    .quotient (quotient),
    .ovf      (ovf),
    .sov      (sov),
    .cond     (cond)
);

// File: tb/int_divider_tb.sv
// Directed bench for int_divider: one task per scenario, each checking
// its own results against a model built from the requirements.
module int_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic        ovf_en = 1'b0;
    logic        rec_en = 1'b0;
    logic        sov_clr = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, ovf, sov;
    logic [31:0] quotient;
    logic [3:0]  cond;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // model state
    logic        m_ovf = 1'b0;
    logic        m_sov = 1'b0;
    logic [3:0]  m_cond = 4'h0;

    always #2 clk = ~clk;   // 250 MHz

    int_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .ovf_en(ovf_en), .rec_en(rec_en), .sov_clr(sov_clr),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .ovf(ovf), .sov(sov), .cond(cond)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Launch one operation, wait for done, check result, flags and latency.
    task automatic run_div(input logic [31:0] a, input logic [31:0] b,
                           input bit sgn, input bit oe, input bit rc,
                           input string req);
        logic [31:0] eq;
        bit          ov;
        int          n;
        ov = (b == 0) || (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
        if (ov) eq = (sgn && b == 0) ? {32{a[31]}} : 32'h0;
        else if (sgn) eq = 32'($signed(a) / $signed(b));
        else eq = a / b;
        if (oe) begin
            m_ovf = ov;
            if (ov) m_sov = 1'b1;
        end
        if (rc) m_cond = {eq[31], !eq[31] && eq != 0, eq == 0, m_sov};
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b;
        signed_mode = sgn; ovf_en = oe; rec_en = rc;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(quotient == eq, req, "quotient", quotient, eq);
        chk(ovf == m_ovf, "R4", "ovf", 32'(ovf), 32'(m_ovf));
        chk(sov == m_sov, "R5", "sov", 32'(sov), 32'(m_sov));
        chk(cond == m_cond, "R6", "cond", 32'(cond), 32'(m_cond));
        chk(n == (ov ? 1 : 33), ov ? "R8" : "R7", "latency", 32'(n),
            32'(ov ? 1 : 33));
        @(negedge clk);
        chk(!done, "R10", "done width", 32'(done), 32'h0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !ovf && !sov, "R11", "ctl/flags",
            {28'h0, busy, done, ovf, sov}, 32'h0);
        chk(quotient == 0 && cond == 0, "R11", "quot/cond",
            quotient | 32'(cond), 32'h0);
    endtask

    task automatic t_unsigned();   // R1
        run_div(32'd100, 32'd7, 0, 1, 1, "R1");
        run_div(32'hFFFF_FFFF, 32'd1, 0, 0, 1, "R1");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1, "R3");
        run_div(32'd5, 32'd9, 0, 0, 1, "R1");
    endtask

    task automatic t_signed();     // R2
        run_div(-32'sd100, 32'sd7, 1, 1, 1, "R2");
        run_div(32'sd100, -32'sd7, 1, 0, 1, "R2");
        run_div(-32'sd99, -32'sd10, 1, 0, 1, "R2");
        run_div(32'h8000_0000, 32'd2, 1, 0, 1, "R2");
    endtask

    task automatic t_corner();     // R3 R8
        run_div(32'd55, 32'd0, 0, 1, 1, "R3");
        chk(!busy, "R8", "busy after corner", 32'(busy), 32'h0);
        run_div(32'h9000_0001, 32'd0, 1, 1, 1, "R3");
        run_div(32'h1234_5678, 32'd0, 1, 1, 1, "R3");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 1, "R3");
    endtask

    task automatic t_sticky();     // R4 R5 R6
        run_div(32'd9, 32'd0, 0, 1, 1, "R3");
        run_div(32'd9, 32'd3, 0, 1, 1, "R4");   // ovf clears, sov holds
        run_div(32'd9, 32'd0, 0, 0, 0, "R4");   // no recording
        @(negedge clk); sov_clr = 1'b1;
        @(negedge clk); sov_clr = 1'b0; m_sov = 1'b0;
        chk(sov == 1'b0, "R5", "sov after clear", 32'(sov), 32'h0);
        chk(cond == m_cond, "R6", "cond kept", 32'(cond), 32'(m_cond));
        run_div(-32'sd6, 32'sd3, 1, 1, 1, "R6");
        run_div(32'd0, 32'd3, 1, 1, 0, "R6");   // cond unchanged
        run_div(32'd1, 32'd0, 0, 1, 1, "R5");   // set again
    endtask

    task automatic t_busy_start(); // R9
        int n;
        logic [31:0] ex;
        ex = 32'd1000 / 32'd3;
        @(negedge clk);
        start = 1'b1; dividend = 32'd1000; divisor = 32'd3;
        signed_mode = 0; ovf_en = 1; rec_en = 0; m_ovf = 1'b0;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; dividend = 32'd7; divisor = 32'd0;
        @(negedge clk); start = 1'b0;
        n = 7;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == 33, "R9", "latency with extra start", 32'(n), 32'd33);
        chk(quotient == ex, "R9", "quotient", quotient, ex);
        chk(ovf == 1'b0, "R9", "ovf", 32'(ovf), 32'h0);
        n = 0;
        repeat (40) begin
            @(negedge clk);
            if (done) n++;
        end
        chk(n == 0, "R9", "extra done", 32'(n), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_unsigned();
        t_signed();
        t_corner();
        t_sticky();
        t_busy_start();
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R7 watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule